// File: doc/BRIEF.md
# Fully Associative Translation Cache with Access Rights

This block holds a small set of recent virtual-to-physical page translations and answers one lookup per cycle. A requester presents a 32-bit virtual address together with its access type (read or write) and privilege (kernel or user). One clock later the block reports exactly one of three outcomes. A hit carries the physical address. A miss tells the requester to walk the page table. A protection fault means the page is cached but this access is not allowed.

Every entry stores a page tag, a physical page number and four status bits: valid, readable, writable and user-accessible. A fifth bit, dirty, is set by the first permitted write. A page-table walker installs translations through a refill port. The refill either overwrites the entry that already holds the same page, or fills the lowest free slot, or evicts the slot named by a rotating pointer. A flush input empties the whole cache in one cycle, for example on an address-space switch.

Top module: `xlat_tlb`

## Requirements
- R1: After synchronous reset no entry is valid, the rotating pointer is 0 and all response outputs are 0; any lookup then reports a miss.
- R2: The page tag is address bits [31:12] and the page offset is bits [11:0]. A hit reports `rsp_pa` = {stored page number, unchanged offset} on the cycle after the request.
- R3: A request whose page tag matches no valid entry raises `rsp_miss` on the next cycle, with `rsp_pa` and `rsp_dirty` at 0.
- R4: For each cycle with `req_valid` high, exactly one of `rsp_hit`, `rsp_miss` and `rsp_fault` is high on the following cycle. All three are low after a cycle with no request.
- R5: A read needs the entry's readable bit and a write needs its writable bit. A matching entry that lacks the needed bit gives `rsp_fault`, with `rsp_pa` = 0 and `rsp_dirty` = 0.
- R6: A user-mode access (`req_user`=1) to an entry whose user bit is 0 faults. A kernel-mode access ignores the user bit, but the read/write rule of R5 still applies.
- R7: A permitted write sets the entry's dirty bit. On a hit `rsp_dirty` shows the dirty bit as it stands after that access. A refill installs the entry clean, and a faulting write leaves the dirty bit unchanged.
- R8: Flush invalidates every entry and returns the pointer to 0 in one cycle. A refill in the same cycle is discarded.
- R9: A refill whose page tag matches a valid entry rewrites that entry (new page number and rights, dirty cleared), so no tag is ever held twice.
- R10: A refill with no matching entry goes to the lowest-index invalid entry. When all entries are valid it goes to the entry named by the pointer, and the pointer then steps by one modulo the entry count. The pointer moves only on such evictions.
- R11: A lookup sees the contents from before the clock edge at which a refill, flush or dirty update in the same cycle takes effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Lookup request present |
| req_va | input | 32 | Virtual address to translate |
| req_wr | input | 1 | 1 = write access, 0 = read |
| req_user | input | 1 | 1 = user mode, 0 = kernel mode |
| fill_valid | input | 1 | Install a translation this cycle |
| fill_vpn | input | 20 | Virtual page tag to install |
| fill_ppn | input | 20 | Physical page number to install |
| fill_rd | input | 1 | Readable right of the new entry |
| fill_wr | input | 1 | Writable right of the new entry |
| fill_usr | input | 1 | User-accessible right of the new entry |
| flush | input | 1 | Invalidate every entry |
| rsp_hit | output | 1 | Translation found and permitted |
| rsp_miss | output | 1 | No matching valid entry |
| rsp_fault | output | 1 | Entry found but access denied |
| rsp_pa | output | 32 | Physical address on a hit, else 0 |
| rsp_dirty | output | 1 | Dirty bit of the hit entry after the access |

## Verification
A corrupted tag, valid bit or page number shows up as a wrong hit/miss decision or a wrong `rsp_pa` on the first lookup of that page after the damage, one cycle after the request. A wrong rights bit or dirty bit appears as a spurious fault or a wrong `rsp_dirty` on the next access to that entry. A misplaced eviction stays hidden until the displaced page or the survivor is looked up again, so the bench re-reads every resident page after each full-cache refill. A reference model tracks the rotating pointer through runs of random refills and flushes, which exposes pointer errors within a few evictions.

// File: rtl/tlb_pkg.sv
package tlb_pkg;

  // Rights decision for one access against one entry.
  function automatic logic access_ok(input logic can_rd, input logic can_wr,
                                     input logic usr_ok, input logic is_wr,
                                     input logic is_user);
    if (is_user && !usr_ok) return 1'b0;
    return is_wr ? can_wr : can_rd;
  endfunction

endpackage

// File: rtl/tlb_cam_match.sv
module tlb_cam_match #(
  parameter int N     = 8,
  parameter int TAG_W = 20
) (
  input  logic [N-1:0]            valid_vec,
  input  logic [N-1:0][TAG_W-1:0] tags,
  input  logic [TAG_W-1:0]        key,
  output logic [N-1:0]            match
);
  for (genvar i = 0; i < N; i++) begin : g_cmp
    assign match[i] = valid_vec[i] && (tags[i] == key);
  end
endmodule

// File: rtl/tlb_victim.sv
module tlb_victim #(
  parameter int N     = 8,
  parameter int IDX_W = $clog2(N)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             flush,
  input  logic             fill_go,
  input  logic [N-1:0]     valid_vec,
  output logic [IDX_W-1:0] victim
);
  logic [IDX_W-1:0] ptr_q;
  logic             free_found;

  always_comb begin
    victim     = ptr_q;
    free_found = 1'b0;
    for (int i = 0; i < N; i++) begin
      if (!free_found && !valid_vec[i]) begin
        victim     = IDX_W'(i);
        free_found = 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst || flush) begin
      ptr_q <= '0;
    end else if (fill_go && !free_found) begin
      ptr_q <= (ptr_q == IDX_W'(N-1)) ? '0 : ptr_q + 1'b1;
    end
  end

  // R10: the pointer stays put while a free slot takes the refill
  assert_ptr_hold_R10: assert property (@(posedge clk) disable iff (rst)
    (fill_go && !flush && !(&valid_vec)) |=> $stable(ptr_q));
endmodule

// File: rtl/xlat_tlb.sv
module xlat_tlb #(
  parameter int VA_W    = 32,
  parameter int OFF_W   = 12,
  parameter int PPN_W   = 20,
  parameter int ENTRIES = 8
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   req_valid,
  input  logic [VA_W-1:0]        req_va,
  input  logic                   req_wr,
  input  logic                   req_user,
  input  logic                   fill_valid,
  input  logic [VA_W-OFF_W-1:0]  fill_vpn,
  input  logic [PPN_W-1:0]       fill_ppn,
  input  logic                   fill_rd,
  input  logic                   fill_wr,
  input  logic                   fill_usr,
  input  logic                   flush,
  output logic                   rsp_hit,
  output logic                   rsp_miss,
  output logic                   rsp_fault,
  output logic [PPN_W+OFF_W-1:0] rsp_pa,
  output logic                   rsp_dirty
);
  localparam int VPN_W = VA_W - OFF_W;
  localparam int PA_W  = PPN_W + OFF_W;
  localparam int IDX_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;

  // entry storage: status flags in vectors, tag and page number in arrays
  logic [ENTRIES-1:0]            v_q, rd_q, wr_q, usr_q, dty_q;
  logic [ENTRIES-1:0][VPN_W-1:0] tag_q;
  logic [ENTRIES-1:0][PPN_W-1:0] ppn_q;

  // lookup side
  logic [VPN_W-1:0]   lk_vpn;
  logic [OFF_W-1:0]   lk_off;
  logic [ENTRIES-1:0] lk_match;
  logic               lk_any;
  logic [IDX_W-1:0]   lk_idx;
  logic               lk_ok, lk_hit, lk_fault, lk_miss;

  assign lk_vpn = req_va[VA_W-1:OFF_W];
  assign lk_off = req_va[OFF_W-1:0];

  tlb_cam_match #(.N(ENTRIES), .TAG_W(VPN_W)) u_lk_cam (
    .valid_vec(v_q), .tags(tag_q), .key(lk_vpn), .match(lk_match)
  );

  always_comb begin
    lk_idx = '0;
    for (int i = 0; i < ENTRIES; i++) begin
      if (lk_match[i]) lk_idx = lk_idx | IDX_W'(i);
    end
  end

  assign lk_any   = |lk_match;
  assign lk_ok    = tlb_pkg::access_ok(rd_q[lk_idx], wr_q[lk_idx], usr_q[lk_idx],
                                       req_wr, req_user);
  assign lk_hit   = req_valid && lk_any && lk_ok;
  assign lk_fault = req_valid && lk_any && !lk_ok;
  assign lk_miss  = req_valid && !lk_any;

  // refill side
  logic [ENTRIES-1:0] fl_match;
  logic               fl_dup;
  logic [IDX_W-1:0]   fl_dup_idx, fl_victim, fl_idx;
  logic               fl_go;

  tlb_cam_match #(.N(ENTRIES), .TAG_W(VPN_W)) u_fl_cam (
    .valid_vec(v_q), .tags(tag_q), .key(fill_vpn), .match(fl_match)
  );

  always_comb begin
    fl_dup_idx = '0;
    for (int i = 0; i < ENTRIES; i++) begin
      if (fl_match[i]) fl_dup_idx = fl_dup_idx | IDX_W'(i);
    end
  end

  assign fl_dup = |fl_match;
  assign fl_go  = fill_valid && !flush && !fl_dup;
  assign fl_idx = fl_dup ? fl_dup_idx : fl_victim;

  tlb_victim #(.N(ENTRIES), .IDX_W(IDX_W)) u_victim (
    .clk(clk), .rst(rst), .flush(flush), .fill_go(fl_go),
    .valid_vec(v_q), .victim(fl_victim)
  );

  // flags: reset and flush clear valid; refill after dirty update so it wins
  always_ff @(posedge clk) begin
    if (rst || flush) begin
      v_q <= '0;
    end else begin
      if (lk_hit && req_wr) dty_q[lk_idx] <= 1'b1;
      if (fill_valid) begin
        v_q[fl_idx]   <= 1'b1;
        rd_q[fl_idx]  <= fill_rd;
        wr_q[fl_idx]  <= fill_wr;
        usr_q[fl_idx] <= fill_usr;
        dty_q[fl_idx] <= 1'b0;
      end
    end
  end

  // tag and page arrays: plain write port, no reset
  always_ff @(posedge clk) begin
    if (fill_valid && !flush && !rst) begin
      tag_q[fl_idx] <= fill_vpn;
      ppn_q[fl_idx] <= fill_ppn;
    end
  end

  // registered response
  always_ff @(posedge clk) begin
    if (rst) begin
      rsp_hit   <= 1'b0;
      rsp_miss  <= 1'b0;
      rsp_fault <= 1'b0;
      rsp_pa    <= '0;
      rsp_dirty <= 1'b0;
    end else begin
      rsp_hit   <= lk_hit;
      rsp_miss  <= lk_miss;
      rsp_fault <= lk_fault;
      rsp_pa    <= lk_hit ? {ppn_q[lk_idx], lk_off} : PA_W'(0);
      rsp_dirty <= lk_hit && (dty_q[lk_idx] || req_wr);
    end
  end

  // R4: at most one outcome at a time
  assert_one_outcome_R4: assert property (@(posedge clk) disable iff (rst)
    $onehot0({rsp_hit, rsp_miss, rsp_fault}));
  // R4: each request answered on the next cycle
  assert_req_answered_R4: assert property (@(posedge clk) disable iff (rst)
    req_valid |=> (rsp_hit || rsp_miss || rsp_fault));
  // R4: silence when nothing was asked
  assert_idle_quiet_R4: assert property (@(posedge clk) disable iff (rst)
    !req_valid |=> !(rsp_hit || rsp_miss || rsp_fault));
  // R2: offset passes through untouched
  assert_offset_kept_R2: assert property (@(posedge clk) disable iff (rst)
    rsp_hit |-> (rsp_pa[OFF_W-1:0] == $past(req_va[OFF_W-1:0])));
  // R5: a fault carries no address
  assert_fault_no_pa_R5: assert property (@(posedge clk) disable iff (rst)
    (rsp_fault || rsp_miss) |-> (rsp_pa == '0 && !rsp_dirty));
  // R7: a granted write reports a dirty page
  assert_write_dirty_R7: assert property (@(posedge clk) disable iff (rst)
    (rsp_hit && $past(req_wr)) |-> rsp_dirty);
  // R8: flush leaves nothing valid
  assert_flush_empty_R8: assert property (@(posedge clk) disable iff (rst)
    flush |=> (v_q == '0));
  // R9: no page tag held twice
  assert_no_dup_R9: assert property (@(posedge clk) disable iff (rst)
    $onehot0(fl_match));
endmodule

// File: tb/sim_xlat_tlb.sv
`timescale 1ns/1ps
module sim_xlat_tlb;
  localparam int N = 8;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        req_valid = 0, req_wr = 0, req_user = 0;
  logic [31:0] req_va = '0;
  logic        fill_valid = 0, fill_rd = 0, fill_wr = 0, fill_usr = 0, flush = 0;
  logic [19:0] fill_vpn = '0, fill_ppn = '0;
  logic        rsp_hit, rsp_miss, rsp_fault, rsp_dirty;
  logic [31:0] rsp_pa;

  always #10 clk = ~clk;

  xlat_tlb u0 (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_va(req_va),
    .req_wr(req_wr), .req_user(req_user), .fill_valid(fill_valid),
    .fill_vpn(fill_vpn), .fill_ppn(fill_ppn), .fill_rd(fill_rd),
    .fill_wr(fill_wr), .fill_usr(fill_usr), .flush(flush),
    .rsp_hit(rsp_hit), .rsp_miss(rsp_miss), .rsp_fault(rsp_fault),
    .rsp_pa(rsp_pa), .rsp_dirty(rsp_dirty)
  );

  // behavioural reference
  bit          m_v[N], m_r[N], m_w[N], m_u[N], m_d[N];
  int unsigned m_tag[N], m_ppn[N];
  int          m_ptr;
  bit          e_hit, e_miss, e_fault, e_dirty;
  logic [31:0] e_pa;
  bit          started = 0;
  string       tag = "R1";
  int          total = 0, bad = 0;

  always @(posedge clk) begin
    if (rst) begin
      foreach (m_v[i]) m_v[i] = 0;
      m_ptr = 0;
      {e_hit, e_miss, e_fault, e_dirty} = '0;
      e_pa = '0;
    end else begin
      int  k;
      bit  ok;
      k = -1;
      foreach (m_v[i]) if (m_v[i] && m_tag[i] == int'(req_va[31:12])) k = i;
      {e_hit, e_miss, e_fault, e_dirty} = '0;
      e_pa = '0;
      if (req_valid) begin
        if (k < 0) e_miss = 1;
        else begin
          ok = !(req_user && !m_u[k]) && (req_wr ? m_w[k] : m_r[k]);
          if (ok) begin
            e_hit   = 1;
            e_pa    = {m_ppn[k][19:0], req_va[11:0]};
            e_dirty = m_d[k] | req_wr;
          end else e_fault = 1;
        end
      end
      if (flush) begin
        foreach (m_v[i]) m_v[i] = 0;
        m_ptr = 0;
      end else begin
        if (e_hit && req_wr) m_d[k] = 1;
        if (fill_valid) begin
          int s;
          s = -1;
          foreach (m_v[i]) if (m_v[i] && m_tag[i] == int'(fill_vpn)) s = i;
          if (s < 0) foreach (m_v[i]) if (s < 0 && !m_v[i]) s = i;
          if (s < 0) begin
            s = m_ptr;
            m_ptr = (m_ptr + 1) % N;
          end
          m_v[s] = 1; m_r[s] = fill_rd; m_w[s] = fill_wr; m_u[s] = fill_usr;
          m_d[s] = 0; m_tag[s] = fill_vpn; m_ppn[s] = fill_ppn;
        end
      end
      started = 1;
    end
  end

  task automatic chk(input string what, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s actual=%h expected=%h t=%0t", tag, what, act, exp, $time);
    end
  endtask

  // compare on every falling edge, clear of the active edge
  always @(negedge clk) begin
    if (started || rst) begin
      chk("hit", 32'(rsp_hit), 32'(e_hit));
      chk("miss", 32'(rsp_miss), 32'(e_miss));
      chk("fault", 32'(rsp_fault), 32'(e_fault));
      chk("pa", rsp_pa, e_pa);
      chk("dirty", 32'(rsp_dirty), 32'(e_dirty));
    end
  end

  task automatic cyc(input bit rv, input logic [31:0] va, input bit w, input bit u,
                     input bit fv, input logic [19:0] vpn, input logic [19:0] ppn,
                     input bit fr, input bit fw, input bit fu, input bit fl);
    @(negedge clk); #1;
    req_valid = rv; req_va = va; req_wr = w; req_user = u;
    fill_valid = fv; fill_vpn = vpn; fill_ppn = ppn;
    fill_rd = fr; fill_wr = fw; fill_usr = fu; flush = fl;
  endtask

  task automatic rd(input logic [31:0] va, input bit u);
    cyc(1, va, 0, u, 0, 0, 0, 0, 0, 0, 0);
  endtask
  task automatic wrt(input logic [31:0] va, input bit u);
    cyc(1, va, 1, u, 0, 0, 0, 0, 0, 0, 0);
  endtask
  task automatic fill(input logic [19:0] vpn, input logic [19:0] ppn,
                      input bit r, input bit w, input bit u);
    cyc(0, 0, 0, 0, 1, vpn, ppn, r, w, u, 0);
  endtask
  task automatic idle();
    cyc(0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0);
  endtask

  initial begin
    #(200000 * 20);
    bad++; total++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    tag = "R1";
    repeat (3) @(negedge clk);
    #1 rst = 0;
    rd(32'h1234_5678, 0);
    idle();
    tag = "R2";
    fill(20'h00A01, 20'hBEEF1, 1, 1, 1);
    rd(32'h00A0_1ABC, 1);
    rd(32'h00A0_1003, 0);
    tag = "R3";
    rd(32'h00A0_2000, 0);
    tag = "R7";
    wrt(32'h00A0_1010, 1);
    rd(32'h00A0_1020, 1);
    tag = "R5";
    fill(20'h00B02, 20'h11111, 1, 0, 1);
    wrt(32'h00B0_2FFF, 0);
    rd(32'h00B0_2FFF, 0);
    fill(20'h00D04, 20'h44444, 0, 1, 1);
    rd(32'h00D0_4004, 1);
    wrt(32'h00D0_4004, 1);
    tag = "R6";
    fill(20'h00C03, 20'h33333, 1, 1, 0);
    rd(32'h00C0_3555, 1);
    wrt(32'h00C0_3555, 1);
    rd(32'h00C0_3555, 0);
    wrt(32'h00C0_3556, 0);
    tag = "R9";
    fill(20'h00A01, 20'h77777, 1, 1, 1);
    rd(32'h00A0_1ABC, 1);
    tag = "R10";
    for (int i = 0; i < 6; i++) fill(20'(32'h100 + i), 20'(32'h9000 + i), 1, 1, 1);
    for (int i = 0; i < 3; i++) fill(20'(32'h200 + i), 20'(32'h8000 + i), 1, 1, 1);
    rd(32'h00A0_1000, 0);
    rd(32'h00B0_2000, 0);
    rd(32'h00C0_3000, 0);
    rd(32'h00D0_4000, 0);
    for (int i = 0; i < 6; i++) rd(32'h0010_0000 + 32'(i) * 32'h1000, 0);
    for (int i = 0; i < 3; i++) rd(32'h0020_0000 + 32'(i) * 32'h1000, 0);
    tag = "R11";
    cyc(1, 32'h0030_0123, 0, 0, 1, 20'h00300, 20'h55555, 1, 1, 1, 0);
    rd(32'h0030_0123, 0);
    cyc(1, 32'h0030_0008, 1, 0, 1, 20'h00300, 20'h66666, 1, 1, 1, 0);
    rd(32'h0030_0008, 0);
    tag = "R8";
    cyc(1, 32'h0030_0008, 0, 0, 1, 20'h00400, 20'h12345, 1, 1, 1, 1);
    rd(32'h0030_0008, 0);
    rd(32'h0040_0000, 0);
    fill(20'h00500, 20'h00005, 1, 1, 1);
    rd(32'h0050_0ABC, 1);
    tag = "R4";
    for (int n = 0; n < 3000; n++) begin
      logic [19:0] v;
      int sel;
      v = 20'h600 + 20'($urandom_range(0, 11));
      sel = $urandom_range(0, 19);
      if (sel == 0)
        cyc(1, {v, 12'($urandom)}, 1'($urandom), 1'($urandom), 0, 0, 0, 0, 0, 0, 1);
      else if (sel < 7)
        cyc(1'($urandom), {20'h600 + 20'($urandom_range(0, 11)), 12'($urandom)},
            1'($urandom), 1'($urandom), 1, v, 20'($urandom),
            1'($urandom), 1'($urandom), 1'($urandom), 0);
      else if (sel < 9)
        idle();
      else
        cyc(1, {v, 12'($urandom)}, 1'($urandom), 1'($urandom), 0, 0, 0, 0, 0, 0, 0);
    end
    idle();
    idle();
    @(negedge clk);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule